// File: doc/BRIEF.md
# Audio Sample-Rate and Clock-Ratio Detector

This block watches the frame clock of a serial audio link and works out two things without any help from software. First, it measures the frame period against a free-running reference clock of known frequency (parameter `REF_HZ`) and sorts the result into a sample-rate class. Second, it counts system-clock cycles between frame edges and matches that count against a fixed list of supported clock-to-frame ratios.

The frame clock is resynchronized separately into the reference domain and the system domain. The ratio code crosses from the system domain into the reference domain, and all outputs are registered on the reference clock. A measurement is trusted only after it has repeated for several frames. A combination that is recognized but not allowed (the implied system clock is too fast, or a ratio of 64 outside the top rate class) raises a separate flag instead of the lock flag.

Top module: `fsr_detect`

## Requirements
- R1: The frame period is the number of `ref_clk` cycles between successive synchronized rising edges of `frame_clk`. A period within ±4 % of REF_HZ/f gives a rate class for these nominal rates f: 8000 Hz → 1, 16000 Hz → 2, 32000/44100/48000 Hz → 3, 88200/96000 Hz → 4, 176400/192000 Hz → 5, 384000 Hz → 6.
- R2: A frame period outside every window of R1 gives `rate_class` = 0.
- R3: The count of `sys_clk` cycles per frame is matched with a tolerance of ±2 against the list 64,128,192,256,384,512,768,1024,1152,1536,2048,3072. `ratio_code` is the 0-based position in that list (64→0 … 3072→11), or 15 when no entry matches.
- R4: Ratio code 0 (64) is allowed only together with class 6. With any other class it raises `unsupported` and never `locked`.
- R5: A combination whose class top rate (1:8 k, 2:16 k, 3:48 k, 4:96 k, 5:192 k, 6:384 k) times the ratio exceeds 49 152 000 Hz raises `unsupported` and never `locked`.
- R6: `locked` rises once 4 consecutive frame measurements have the same class (not 0) and ratio (not 15) and the combination is allowed. `unsupported` is raised under the same conditions when the combination is not allowed. The two flags are never high together.
- R7: `locked` falls at the first frame measurement that differs from the one it was locked on.
- R8: If no rising frame edge arrives for 2·REF_HZ/8000 `ref_clk` cycles, the block returns to `rate_class`=0, `ratio_code`=15, `locked`=0 and `unsupported`=0. It recovers and locks again once valid frames resume.
- R9: While `rst_n` is low at a clock edge, the outputs are `rate_class`=0, `ratio_code`=15, `locked`=0 and `unsupported`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock of known frequency REF_HZ; all outputs are in this domain |
| sys_clk | input | 1 | Audio system clock, up to 50 MHz |
| rst_n | input | 1 | Synchronous active-low reset, applied in both clock domains |
| frame_clk | input | 1 | Asynchronous frame (left/right) clock to be measured |
| rate_class | output | 3 | Latest sample-rate class, 0 = none |
| ratio_code | output | 4 | Latest ratio index, 15 = no match |
| locked | output | 1 | Stable, supported rate and ratio |
| unsupported | output | 1 | Stable but disallowed rate/ratio combination |

## Verification
On every cycle, the assertions check the following. The two flags never overlap. A locked ratio of 64 always belongs to class 6. A timeout clears the state on the next cycle. A differing measurement drops the lock. The lock rises only on a frame boundary. The counters stay within their saturation limits. Only the bench scenarios can show that the ±4 % windows sort real frame periods into the right groups, that each ratio in the list is recognized, and that the speed limit on combinations sorts cases into lock or error. They also show that the lock returns after a timeout.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int NUM_RATIOS = 12;
    localparam int NUM_RATES  = 10;

    localparam logic [3:0] RATIO_NONE = 4'hF;

    localparam logic [2:0] CLS_NONE   = 3'd0;
    localparam logic [2:0] CLS_8K     = 3'd1;
    localparam logic [2:0] CLS_16K    = 3'd2;
    localparam logic [2:0] CLS_SINGLE = 3'd3;
    localparam logic [2:0] CLS_DOUBLE = 3'd4;
    localparam logic [2:0] CLS_QUAD   = 3'd5;
    localparam logic [2:0] CLS_OCTO   = 3'd6;

    // system-clock cycles per frame, in code order
    function automatic int unsigned ratio_value(int idx);
        case (idx)
            0:       return 64;
            1:       return 128;
            2:       return 192;
            3:       return 256;
            4:       return 384;
            5:       return 512;
            6:       return 768;
            7:       return 1024;
            8:       return 1152;
            9:       return 1536;
            10:      return 2048;
            default: return 3072;
        endcase
    endfunction

    // nominal frame rates in Hz
    function automatic int unsigned rate_hz(int idx);
        case (idx)
            0:       return 8000;
            1:       return 16000;
            2:       return 32000;
            3:       return 44100;
            4:       return 48000;
            5:       return 88200;
            6:       return 96000;
            7:       return 176400;
            8:       return 192000;
            default: return 384000;
        endcase
    endfunction

    function automatic logic [2:0] rate_class(int idx);
        case (idx)
            0:          return CLS_8K;
            1:          return CLS_16K;
            2, 3, 4:    return CLS_SINGLE;
            5, 6:       return CLS_DOUBLE;
            7, 8:       return CLS_QUAD;
            default:    return CLS_OCTO;
        endcase
    endfunction

    // highest nominal rate inside a class
    function automatic int unsigned class_top_hz(logic [2:0] c);
        case (c)
            CLS_8K:     return 8000;
            CLS_16K:    return 16000;
            CLS_SINGLE: return 48000;
            CLS_DOUBLE: return 96000;
            CLS_QUAD:   return 192000;
            CLS_OCTO:   return 384000;
            default:    return 0;
        endcase
    endfunction

    function automatic logic combo_ok(logic [2:0] c, logic [3:0] r, int unsigned max_hz);
        if (c == CLS_NONE || c > CLS_OCTO || r > 4'd11) return 1'b0;
        if (r == 4'd0 && c != CLS_OCTO) return 1'b0;
        return (class_top_hz(c) * ratio_value(int'(r))) <= max_hz;
    endfunction

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/fsr_ratio_meter.sv
module fsr_ratio_meter
    import fsr_pkg::*;
#(
    parameter int RATIO_TOL = 2
) (
    input  logic       sys_clk,
    input  logic       rst_n,
    input  logic       frame_async,
    output logic [3:0] ratio_code
);
    localparam int unsigned CMAX = ratio_value(NUM_RATIOS-1) + RATIO_TOL + 1;
    localparam int          CW   = $clog2(CMAX + 1);

    typedef struct packed {
        logic          prev;
        logic          seen;
        logic [CW-1:0] cnt;
        logic [3:0]    code;
    } st_t;

    st_t  d, q;
    logic fs;
    logic [31:0] cnt_w;
    logic [NUM_RATIOS-1:0] hit;
    logic [3:0] match;

    fsr_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_fsync (
        .clk(sys_clk), .rst_n(rst_n), .din(frame_async), .dout(fs)
    );

    assign cnt_w = 32'(q.cnt);

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
        localparam int unsigned LO = ratio_value(i) - RATIO_TOL;
        localparam int unsigned HI = ratio_value(i) + RATIO_TOL;
        assign hit[i] = (cnt_w >= LO) && (cnt_w <= HI);
    end

    always_comb begin
        match = RATIO_NONE;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) match = 4'(i);
        end
    end

    always_comb begin
        d      = q;
        d.prev = fs;
        if (fs && !q.prev) begin
            if (q.seen) d.code = match;
            d.seen = 1'b1;
            d.cnt  = CW'(1);
        end else if (q.cnt == CW'(CMAX)) begin
            d.code = RATIO_NONE;
            d.seen = 1'b0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            q.prev <= 1'b0;
            q.seen <= 1'b0;
            q.cnt  <= '0;
            q.code <= RATIO_NONE;
        end else begin
            q <= d;
        end
    end

    assign ratio_code = q.code;

    a_r3_code_legal: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (q.code <= 4'd11) || (q.code == RATIO_NONE));

    a_r3_cnt_bound: assert property (@(posedge sys_clk) disable iff (!rst_n)
        32'(q.cnt) <= CMAX);
endmodule

// File: rtl/fsr_rate_meter.sv
module fsr_rate_meter
    import fsr_pkg::*;
#(
    parameter int unsigned REF_HZ  = 24576000,
    parameter int unsigned TOL_PCT = 4
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       frame_async,
    output logic       meas_edge,
    output logic [2:0] meas_cls,
    output logic       timeout
);
    localparam int unsigned TIMEOUT = 2 * REF_HZ / rate_hz(0);
    localparam int          CW      = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic          prev;
        logic          seen;
        logic [CW-1:0] cnt;
        logic          edge_s;
        logic [2:0]    cls;
        logic          tout;
    } st_t;

    st_t  d, q;
    logic fs;
    logic [31:0] cnt_w;
    logic [2:0]  cls_hit [NUM_RATES];
    logic [2:0]  cls_now;

    fsr_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_fsync (
        .clk(ref_clk), .rst_n(rst_n), .din(frame_async), .dout(fs)
    );

    assign cnt_w = 32'(q.cnt);

    for (genvar i = 0; i < NUM_RATES; i++) begin : g_band
        localparam int unsigned NOM = REF_HZ / rate_hz(i);
        localparam int unsigned TOL = NOM * TOL_PCT / 100;
        localparam int unsigned LO  = NOM - TOL;
        localparam int unsigned HI  = NOM + TOL;
        assign cls_hit[i] = ((cnt_w >= LO) && (cnt_w <= HI)) ? rate_class(i) : CLS_NONE;
    end

    always_comb begin
        cls_now = CLS_NONE;
        for (int i = 0; i < NUM_RATES; i++) cls_now = cls_now | cls_hit[i];
    end

    always_comb begin
        d        = q;
        d.prev   = fs;
        d.edge_s = 1'b0;
        d.tout   = 1'b0;
        if (fs && !q.prev) begin
            if (q.seen) begin
                d.edge_s = 1'b1;
                d.cls    = cls_now;
            end
            d.seen = 1'b1;
            d.cnt  = CW'(1);
        end else if (q.cnt == CW'(TIMEOUT)) begin
            if (q.seen) d.tout = 1'b1;
            d.seen = 1'b0;
            d.cls  = CLS_NONE;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            q.prev   <= 1'b0;
            q.seen   <= 1'b0;
            q.cnt    <= '0;
            q.edge_s <= 1'b0;
            q.cls    <= CLS_NONE;
            q.tout   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign meas_edge = q.edge_s;
    assign meas_cls  = q.cls;
    assign timeout   = q.tout;

    a_r8_cnt_bound: assert property (@(posedge ref_clk) disable iff (!rst_n)
        32'(q.cnt) <= TIMEOUT);

    a_r8_tout_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
        q.tout |=> !q.tout);
endmodule

// File: rtl/fsr_lock_ctrl.sv
module fsr_lock_ctrl
    import fsr_pkg::*;
#(
    parameter int unsigned MAX_SYS_HZ  = 49152000,
    parameter int          LOCK_FRAMES = 4
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       meas_edge,
    input  logic [2:0] meas_cls,
    input  logic       timeout,
    input  logic [3:0] ratio_async,
    output logic [2:0] rate_class,
    output logic [3:0] ratio_code,
    output logic       locked,
    output logic       unsupported
);
    localparam int AW = $clog2(LOCK_FRAMES + 1);

    typedef struct packed {
        logic [3:0]    rprev;
        logic [3:0]    rstable;
        logic [2:0]    cls;
        logic [3:0]    ratio;
        logic [AW-1:0] agree;
        logic          locked;
        logic          unsup;
    } st_t;

    st_t  d, q;
    logic [3:0]    rs;
    logic          same, known, ok;
    logic [AW-1:0] agree_n;

    fsr_sync #(.WIDTH(4), .RST_VAL(RATIO_NONE)) u_rsync (
        .clk(ref_clk), .rst_n(rst_n), .din(ratio_async), .dout(rs)
    );

    always_comb begin
        same    = (meas_cls == q.cls) && (q.rstable == q.ratio) && (q.agree != '0);
        agree_n = same ? ((q.agree == AW'(LOCK_FRAMES)) ? q.agree : q.agree + 1'b1)
                       : AW'(1);
        known   = (meas_cls != CLS_NONE) && (q.rstable != RATIO_NONE);
        ok      = combo_ok(meas_cls, q.rstable, MAX_SYS_HZ);
    end

    always_comb begin
        d       = q;
        d.rprev = rs;
        if (rs == q.rprev) d.rstable = rs;
        if (timeout) begin
            d.cls    = CLS_NONE;
            d.ratio  = RATIO_NONE;
            d.agree  = '0;
            d.locked = 1'b0;
            d.unsup  = 1'b0;
        end else if (meas_edge) begin
            d.cls    = meas_cls;
            d.ratio  = q.rstable;
            d.agree  = agree_n;
            d.locked = (agree_n == AW'(LOCK_FRAMES)) && known && ok;
            d.unsup  = (agree_n == AW'(LOCK_FRAMES)) && known && !ok;
        end
    end

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            q.rprev   <= RATIO_NONE;
            q.rstable <= RATIO_NONE;
            q.cls     <= CLS_NONE;
            q.ratio   <= RATIO_NONE;
            q.agree   <= '0;
            q.locked  <= 1'b0;
            q.unsup   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rate_class  = q.cls;
    assign ratio_code  = q.ratio;
    assign locked      = q.locked;
    assign unsupported = q.unsup;

    a_r6_flags_exclusive: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(q.locked && q.unsup));

    a_r6_lock_on_frame: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(q.locked) |-> $past(meas_edge));

    a_r4_ratio64_top_only: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (q.locked && q.ratio == 4'd0) |-> (q.cls == CLS_OCTO));

    a_r7_drop_on_change: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (meas_edge && q.locked && (meas_cls != q.cls)) |=> !q.locked);

    a_r8_timeout_clears: assert property (@(posedge ref_clk) disable iff (!rst_n)
        timeout |=> (!q.locked && !q.unsup && q.cls == CLS_NONE && q.ratio == RATIO_NONE));
endmodule

// File: rtl/fsr_detect.sv
module fsr_detect
    import fsr_pkg::*;
#(
    parameter int unsigned REF_HZ      = 24576000,
    parameter int unsigned TOL_PCT     = 4,
    parameter int          RATIO_TOL   = 2,
    parameter int          LOCK_FRAMES = 4,
    parameter int unsigned MAX_SYS_HZ  = 49152000
) (
    input  logic       ref_clk,
    input  logic       sys_clk,
    input  logic       rst_n,
    input  logic       frame_clk,
    output logic [2:0] rate_class,
    output logic [3:0] ratio_code,
    output logic       locked,
    output logic       unsupported
);
    logic [3:0] sys_ratio;
    logic       meas_edge, tout;
    logic [2:0] meas_cls;

    fsr_ratio_meter #(.RATIO_TOL(RATIO_TOL)) u_ratio (
        .sys_clk(sys_clk), .rst_n(rst_n), .frame_async(frame_clk), .ratio_code(sys_ratio)
    );

    fsr_rate_meter #(.REF_HZ(REF_HZ), .TOL_PCT(TOL_PCT)) u_rate (
        .ref_clk(ref_clk), .rst_n(rst_n), .frame_async(frame_clk),
        .meas_edge(meas_edge), .meas_cls(meas_cls), .timeout(tout)
    );

    fsr_lock_ctrl #(.MAX_SYS_HZ(MAX_SYS_HZ), .LOCK_FRAMES(LOCK_FRAMES)) u_lock (
        .ref_clk(ref_clk), .rst_n(rst_n), .meas_edge(meas_edge), .meas_cls(meas_cls),
        .timeout(tout), .ratio_async(sys_ratio), .rate_class(rate_class),
        .ratio_code(ratio_code), .locked(locked), .unsupported(unsupported)
    );
endmodule

// File: tb/sim_fsr_detect.sv
module sim_fsr_detect;
    timeunit 1ps;
    timeprecision 1ps;

    localparam int  REF_PERIOD_PS = 40690;
    localparam real REF_HZ_R      = 24576000.0;
    localparam int  TIMEOUT_CYC   = 6144;
    localparam int  WATCHDOG_CYC  = 200000;

    logic ref_clk = 1'b0;
    logic sys_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic frame_clk = 1'b0;
    logic [2:0] rate_class;
    logic [3:0] ratio_code;
    logic locked, unsupported;

    int sys_half    = 10000;
    int frame_ratio = 256;
    int fcnt        = 0;
    bit frame_en    = 1'b0;
    int errors      = 0;
    int checks      = 0;
    bit done        = 1'b0;

    fsr_detect u0 (
        .ref_clk(ref_clk), .sys_clk(sys_clk), .rst_n(rst_n), .frame_clk(frame_clk),
        .rate_class(rate_class), .ratio_code(ratio_code),
        .locked(locked), .unsupported(unsupported)
    );

    initial forever #(REF_PERIOD_PS/2) ref_clk = ~ref_clk;
    initial begin
        #7000;
        forever #(sys_half) sys_clk = ~sys_clk;
    end

    always @(posedge sys_clk) begin
        if (!frame_en) begin
            fcnt      <= 0;
            frame_clk <= 1'b0;
        end else begin
            fcnt      <= (fcnt + 1 >= frame_ratio) ? 0 : fcnt + 1;
            frame_clk <= (fcnt < frame_ratio / 2);
        end
    end

    task automatic set_stream(real fs, int ratio);
        sys_half    = $rtoi(5.0e11 / (fs * ratio) + 0.5);
        frame_ratio = ratio;
        frame_en    = 1'b1;
    endtask

    task automatic wait_frames(int n, real fs);
        int cyc = $rtoi(n * REF_HZ_R / fs) + 40;
        repeat (cyc) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    task automatic check_out(string req, int ec, int er, bit el, bit eu);
        checks++;
        if (rate_class !== 3'(ec) || ratio_code !== 4'(er) ||
            locked !== el || unsupported !== eu) begin
            errors++;
            $display("FAIL %s: got class=%0d ratio=%0d locked=%0b unsup=%0b, expected class=%0d ratio=%0d locked=%0b unsup=%0b",
                     req, rate_class, ratio_code, locked, unsupported, ec, er, el, eu);
        end
    endtask

    task automatic t_reset;      // R9
        check_out("R9 reset state", 0, 15, 0, 0);
    endtask

    task automatic t_single_48k; // R1 R3 R6
        set_stream(48000.0, 256); wait_frames(10, 48000.0);
        check_out("R1 R3 R6 48k x256", 3, 3, 1, 0);
    endtask

    task automatic t_single_44k; // R1 R3
        set_stream(44100.0, 512); wait_frames(10, 44100.0);
        check_out("R1 R3 44.1k x512", 3, 5, 1, 0);
    endtask

    task automatic t_octo_64;    // R4
        set_stream(384000.0, 64); wait_frames(12, 384000.0);
        check_out("R4 384k x64", 6, 0, 1, 0);
    endtask

    task automatic t_8k_3072;    // R1 R3
        set_stream(8000.0, 3072); wait_frames(8, 8000.0);
        check_out("R1 R3 8k x3072", 1, 11, 1, 0);
    endtask

    task automatic t_16k_1536;   // R1 R3
        set_stream(16000.0, 1536); wait_frames(9, 16000.0);
        check_out("R1 R3 16k x1536", 2, 9, 1, 0);
    endtask

    task automatic t_quad_128;   // R1
        set_stream(192000.0, 128); wait_frames(12, 192000.0);
        check_out("R1 192k x128", 5, 1, 1, 0);
    endtask

    task automatic t_double_64;  // R4
        set_stream(96000.0, 64); wait_frames(12, 96000.0);
        check_out("R4 96k x64 rejected", 4, 0, 0, 1);
    endtask

    task automatic t_single_1152; // R5
        set_stream(48000.0, 1152); wait_frames(10, 48000.0);
        check_out("R5 48k x1152 too fast", 3, 8, 0, 1);
    endtask

    task automatic t_quad_384;   // R5
        set_stream(192000.0, 384); wait_frames(12, 192000.0);
        check_out("R5 192k x384 too fast", 5, 4, 0, 1);
    endtask

    task automatic t_off_band;   // R2
        set_stream(60000.0, 256); wait_frames(10, 60000.0);
        check_out("R2 60k no class", 0, 3, 0, 0);
    endtask

    task automatic t_bad_ratio;  // R3
        set_stream(48000.0, 300); wait_frames(10, 48000.0);
        check_out("R3 ratio 300 no match", 3, 15, 0, 0);
    endtask

    task automatic t_tolerance;  // R1 R2
        set_stream(49440.0, 256); wait_frames(10, 49440.0);
        check_out("R1 +3% accepted", 3, 3, 1, 0);
        set_stream(31040.0, 256); wait_frames(10, 31040.0);
        check_out("R1 -3% of 32k accepted", 3, 3, 1, 0);
        set_stream(51360.0, 256); wait_frames(10, 51360.0);
        check_out("R2 +7% rejected", 0, 3, 0, 0);
    endtask

    task automatic t_drop;       // R7
        set_stream(48000.0, 256); wait_frames(10, 48000.0);
        check_out("R7 locked before change", 3, 3, 1, 0);
        set_stream(96000.0, 256);
        repeat (790) @(posedge ref_clk);
        @(negedge ref_clk);
        checks++;
        if (locked !== 1'b0) begin
            errors++;
            $display("FAIL R7 lock kept after rate change: got locked=%0b expected 0", locked);
        end
        wait_frames(10, 96000.0);
        check_out("R1 R7 relock 96k", 4, 3, 1, 0);
    endtask

    task automatic t_timeout;    // R8
        frame_en = 1'b0;
        repeat (TIMEOUT_CYC + 600) @(posedge ref_clk);
        @(negedge ref_clk);
        check_out("R8 timeout clears", 0, 15, 0, 0);
        set_stream(48000.0, 256); wait_frames(10, 48000.0);
        check_out("R8 recovery", 3, 3, 1, 0);
    endtask

    initial begin
        repeat (20) @(posedge ref_clk);
        @(negedge ref_clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(posedge ref_clk);
        @(negedge ref_clk);
        t_reset();
        t_single_48k();
        t_single_44k();
        t_octo_64();
        t_8k_3072();
        t_16k_1536();
        t_quad_128();
        t_double_64();
        t_single_1152();
        t_quad_384();
        t_off_band();
        t_bad_ratio();
        t_tolerance();
        t_drop();
        t_timeout();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge ref_clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", WATCHDOG_CYC);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule